// File: doc/BRIEF.md
# Dithered Dual-Resolution PWM Generator

This block drives one pulse-width-modulated pin from an 8-bit duty word. It splits a full 256-clock period into four equal sub-cycles of 64 clocks each. The six upper bits of the duty word set a base number of high clocks that every sub-cycle receives. The two lower bits choose how many of the leading sub-cycles get one extra high clock. The average duty therefore resolves to 1/256 of the period, while the ripple at the output stays at the 64-clock sub-cycle rate. This keeps the external filter small.

In each sub-cycle the pin rises on the first clock. It stays high for that sub-cycle's count and then stays low until the sub-cycle ends. A one-clock strobe marks the first clock of every full period. The duty word is captured only at that point, so software may write it at any time without splitting a period.

When the enable input is dropped, the pin and the strobe are forced low and the position counter returns to zero. When enable rises again, a fresh period begins.

Top module: `dpwm_gen`

## Requirements
- R1: A sub-cycle lasts 2^SUB_BITS clocks (64 by default) and a full period holds 2^DITH_BITS sub-cycles (four by default, 256 clocks). `period_strobe_o` is high for exactly one clock per period, on the first clock of sub-cycle 0.
- R2: With the two duty LSBs at 0, every sub-cycle is high for duty[7:2] clocks (duty 100 gives 25 high clocks in each of the four sub-cycles).
- R3: Sub-cycle k (k = 0..3) is high for duty[7:2] + 1 clocks when k < duty[1:0], and for duty[7:2] clocks otherwise (101 gives 26,25,25,25; 102 gives 26,26,25,25; 103 gives 26,26,26,25).
- R4: Within a sub-cycle the high clocks are contiguous and start on its first clock. A count of 0 keeps the pin low for the whole sub-cycle, and a count of 64 keeps it high for the whole sub-cycle.
- R5: `duty_i` is sampled only on the first clock of sub-cycle 0. A change made in the middle of a period first shows in the next period.
- R6: While `en` is low, `pwm_o` and `period_strobe_o` are low from the next clock on and the position counter is cleared. The first enabled clock after that starts sub-cycle 0 with a strobe.
- R7: While `rst_n` is low (asynchronous, active low), both outputs are low. After release, the first enabled clock starts a period.
- R8: Both outputs are registered. The first high clock of a period coincides with the strobe, one clock after `en` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces outputs low and clears the counter |
| duty_i | input | 8 | Duty word: [7:2] base high count, [1:0] number of dithered sub-cycles |
| pwm_o | output | 1 | PWM pin |
| period_strobe_o | output | 1 | One-clock pulse on the first clock of each period |

## Verification
The bench builds the block with its default parameters: 6 sub-cycle bits and 2 dither bits. Because a full period is only 256 clocks, every vector can be compared over whole periods, both for high-clock counts and for the shape of each sub-cycle. The defaults also bring the count extremes within reach. Counts of 0 and 1 reach the all-low edge, and duty 254 and 255 reach sub-cycles that are high for all 64 clocks, which needs the seventh bit of the high count. A mid-period duty write, a disable in the middle of a period and a reset in the middle of a period each run against the same period walker.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  // High clocks for one sub-cycle: base from the upper bits, plus one when
  // the sub-cycle index is below the fractional (low) bits.
  function automatic int unsigned high_count(int unsigned duty,
                                             int unsigned sub_idx,
                                             int unsigned dith_bits);
    int unsigned base;
    int unsigned frac;
    base = duty >> dith_bits;
    frac = duty & ((32'd1 << dith_bits) - 32'd1);
    return base + ((sub_idx < frac) ? 32'd1 : 32'd0);
  endfunction

  // Length of one sub-cycle in clocks.
  function automatic int unsigned sub_len(int unsigned sub_bits);
    return 32'd1 << sub_bits;
  endfunction

endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int SUB_BITS  = 6,
  parameter int DITH_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  output logic [DITH_BITS-1:0] sub_idx,
  output logic [SUB_BITS-1:0]  sub_cnt,
  output logic                 period_start
);
  localparam int POS_W = SUB_BITS + DITH_BITS;

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pos_q <= '0;
    else if (!en) pos_q <= '0;
    else          pos_q <= pos_q + 1'b1;
  end

  assign {sub_idx, sub_cnt} = pos_q;
  assign period_start       = en && (pos_q == '0);

  AST_START_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> (pos_q == POS_W'(1)));  // R1
  AST_PERIOD_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pos_q == '1) |=> (pos_q == '0));  // R1
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pos_q == '0));  // R6
endmodule

// File: rtl/dpwm_duty_hold.sv
module dpwm_duty_hold #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-1:0] duty_eff
);
  logic [DUTY_W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow_q <= '0;
    else if (load) shadow_q <= duty_i;
  end

  // On the load clock the incoming word is used directly, so the new value
  // governs the very first clock of the period.
  assign duty_eff = load ? duty_i : shadow_q;

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shadow_q));  // R5
endmodule

// File: rtl/dpwm_shape.sv
module dpwm_shape #(
  parameter int SUB_BITS  = 6,
  parameter int DITH_BITS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          period_start,
  input  logic [SUB_BITS+DITH_BITS-1:0] duty_eff,
  input  logic [DITH_BITS-1:0]          sub_idx,
  input  logic [SUB_BITS-1:0]           sub_cnt,
  output logic                          pwm_o,
  output logic                          strobe_o
);
  localparam int HC_W = SUB_BITS + 1;
  localparam logic [HC_W-1:0] FULL = HC_W'(dpwm_pkg::sub_len(SUB_BITS));

  logic [HC_W-1:0] high_cnt;
  logic            level_next;
  logic            pwm_q;
  logic            strobe_q;

  assign high_cnt   = HC_W'(dpwm_pkg::high_count(32'(duty_eff), 32'(sub_idx), DITH_BITS));
  assign level_next = en && ({1'b0, sub_cnt} < high_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      pwm_q    <= level_next;
      strobe_q <= period_start;
    end
  end

  assign pwm_o    = pwm_q;
  assign strobe_o = strobe_q;

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (high_cnt <= FULL));  // R2
  AST_ZERO_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && high_cnt == '0) |=> !pwm_q);  // R4
  AST_FULL_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && high_cnt == FULL) |=> pwm_q);  // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);  // R1
  AST_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_q && !strobe_q));  // R6
endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen #(
  parameter int SUB_BITS  = 6,
  parameter int DITH_BITS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [SUB_BITS+DITH_BITS-1:0] duty_i,
  output logic                          pwm_o,
  output logic                          period_strobe_o
);
  localparam int DUTY_W = SUB_BITS + DITH_BITS;

  logic [DITH_BITS-1:0] sub_idx;
  logic [SUB_BITS-1:0]  sub_cnt;
  logic                 period_start;
  logic [DUTY_W-1:0]    duty_eff;

  dpwm_timebase #(.SUB_BITS(SUB_BITS), .DITH_BITS(DITH_BITS)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en),
    .sub_idx(sub_idx), .sub_cnt(sub_cnt), .period_start(period_start)
  );

  dpwm_duty_hold #(.DUTY_W(DUTY_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(period_start),
    .duty_i(duty_i), .duty_eff(duty_eff)
  );

  dpwm_shape #(.SUB_BITS(SUB_BITS), .DITH_BITS(DITH_BITS)) u_shape (
    .clk(clk), .rst_n(rst_n), .en(en), .period_start(period_start),
    .duty_eff(duty_eff), .sub_idx(sub_idx), .sub_cnt(sub_cnt),
    .pwm_o(pwm_o), .strobe_o(period_strobe_o)
  );

  AST_STROBE_WITH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_strobe_o) |-> $past(en));  // R8
endmodule

// File: tb/dpwm_gen_test.sv
`timescale 1ns/1ps
module dpwm_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] duty_i = 8'd0;
  logic       pwm_o;
  logic       period_strobe_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dpwm_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .duty_i(duty_i),
    .pwm_o(pwm_o), .period_strobe_o(period_strobe_o)
  );

  // {duty, exp sub0, exp sub1, exp sub2, exp sub3}
  localparam int NVEC = 12;
  localparam logic [35:0] VEC [0:NVEC-1] = '{
    {8'd0,   7'd0,  7'd0,  7'd0,  7'd0},
    {8'd1,   7'd1,  7'd0,  7'd0,  7'd0},
    {8'd2,   7'd1,  7'd1,  7'd0,  7'd0},
    {8'd3,   7'd1,  7'd1,  7'd1,  7'd0},
    {8'd4,   7'd1,  7'd1,  7'd1,  7'd1},
    {8'd100, 7'd25, 7'd25, 7'd25, 7'd25},
    {8'd101, 7'd26, 7'd25, 7'd25, 7'd25},
    {8'd102, 7'd26, 7'd26, 7'd25, 7'd25},
    {8'd103, 7'd26, 7'd26, 7'd26, 7'd25},
    {8'd128, 7'd32, 7'd32, 7'd32, 7'd32},
    {8'd254, 7'd64, 7'd64, 7'd63, 7'd63},
    {8'd255, 7'd64, 7'd64, 7'd64, 7'd63}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent restatement: which sub-cycles get the extra clock.
  function automatic int ref_hc(input logic [7:0] d, input int s);
    int extra;
    extra = 0;
    case (d[1:0])
      2'd1: extra = (s == 0) ? 1 : 0;
      2'd2: extra = (s <= 1) ? 1 : 0;
      2'd3: extra = (s != 3) ? 1 : 0;
      default: extra = 0;
    endcase
    return int'(d / 4) + extra;
  endfunction

  function automatic logic [27:0] ref_pack(input logic [7:0] d);
    return {7'(ref_hc(d, 0)), 7'(ref_hc(d, 1)), 7'(ref_hc(d, 2)), 7'(ref_hc(d, 3))};
  endfunction

  // Idle one clock, then enable with a fresh duty word.
  task automatic restart(input logic [7:0] d);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    duty_i = d;
    en = 1'b1;
  endtask

  // Walk one 256-clock period; optionally write a new duty at change_at.
  task automatic run_period(input logic [27:0] exp, input string req,
                            input int change_at, input logic [7:0] new_duty);
    int  hi [4];
    bit  seen_low [4];
    bit  broken [4];
    int  strobes;
    bit  first_ok;
    for (int s = 0; s < 4; s++) begin
      hi[s] = 0; seen_low[s] = 1'b0; broken[s] = 1'b0;
    end
    strobes = 0;
    first_ok = 1'b0;
    for (int i = 0; i < 256; i++) begin
      int s;
      @(negedge clk);
      s = i / 64;
      if (pwm_o) begin
        hi[s]++;
        if (seen_low[s]) broken[s] = 1'b1;
      end else begin
        seen_low[s] = 1'b1;
      end
      if (period_strobe_o) strobes++;
      if (i == 0) first_ok = period_strobe_o;
      if (i == change_at) duty_i = new_duty;
    end
    chk(strobes == 1 && first_ok, "R1/R8", "strobe once at first clock",
        strobes, 1);
    for (int s = 0; s < 4; s++) begin
      int e;
      e = int'(exp[27 - 7*s -: 7]);
      chk(hi[s] == e, req, $sformatf("high clocks sub%0d", s), hi[s], e);
      chk(!broken[s], "R4", $sformatf("contiguous from start sub%0d", s),
          int'(broken[s]), 0);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R7: outputs low while reset is held, even with enable and duty set.
    en = 1'b1;
    duty_i = 8'd255;
    repeat (5) @(negedge clk);
    chk(!pwm_o && !period_strobe_o, "R7", "outputs in reset",
        int'({pwm_o, period_strobe_o}), 0);
    en = 1'b0;
    rst_n = 1'b1;

    // Table walk: R2/R3/R4 over count patterns.
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] d;
      d = VEC[v][35:28];
      restart(d);
      run_period(VEC[v][27:0], (d[1:0] == 2'd0) ? "R2" : "R3", -1, 8'd0);
      chk(VEC[v][27:0] == ref_pack(d), "R3", "table vs reference",
          int'(VEC[v][27:0]), int'(ref_pack(d)));
    end

    // R5: mid-period write only applies in the next period.
    restart(8'd101);
    run_period(ref_pack(8'd101), "R5", 100, 8'd3);
    run_period(ref_pack(8'd3), "R5", -1, 8'd0);
    run_period(ref_pack(8'd3), "R5", 200, 8'd200);
    run_period(ref_pack(8'd200), "R5", -1, 8'd0);

    // R6: disable mid-period forces outputs low; re-enable restarts.
    restart(8'd128);
    repeat (10) @(negedge clk);
    en = 1'b0;
    duty_i = 8'd255;
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (pwm_o || period_strobe_o) bad++;
      end
      chk(bad == 0, "R6", "outputs low while disabled", bad, 0);
    end
    en = 1'b1;
    run_period(ref_pack(8'd255), "R6", -1, 8'd0);

    // R7: asynchronous reset mid-period, then a fresh period.
    restart(8'd255);
    repeat (40) @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk(!pwm_o && !period_strobe_o, "R7", "outputs after async reset",
           int'({pwm_o, period_strobe_o}), 0);
    @(negedge clk);
    duty_i = 8'd6;
    rst_n = 1'b1;
    run_period(ref_pack(8'd6), "R7", -1, 8'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule